// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer

This block caches translation entries for a 32-bit virtual address space built from 4 KB pages. A lookup presents a 20-bit virtual page number and a 12-bit page offset. One clock later the block reports whether a page-level entry for that page is held. On a hit it returns the cached 32-bit entry and the physical address, formed from the entry's upper 20 bits followed by the untranslated offset. The same response also reports whether a directory-level entry covering the page is held. A page walker can then skip the directory read on a miss.

Storage is 16 sets of 4 ways. Each entry holds a 32-bit table word, a 16-bit tag, a type flag and a valid flag. The response carries a victim way for the page set and a victim way for the directory set. The walker returns that way with its refill. A task-switch flush drops every entry whose global bit is clear, all in one cycle. A single-page invalidate removes the entries that a lookup of that page would hit.

Top module: `set_assoc_tlb`

## Requirements
- R1: The page-level set index is vpn[3:0] and the stored tag is vpn[19:4]. A refill into one set never changes what a lookup in another set returns.
- R2: On a page-level hit, `rsp_hit`=1 and `rsp_ent` is the stored entry. `rsp_paddr` = {entry[31:12], offset}, where the offset is the one presented with the lookup.
- R3: On a page-level miss, `rsp_hit`, `rsp_ent` and `rsp_paddr` are all zero.
- R4: A directory-level entry (`fill_dir`=1) is stored in set vpn[13:10]. It matches any lookup with equal vpn[19:10], whatever vpn[9:0] is, and is reported on `rsp_dir_hit`/`rsp_dir_ent` (zero on a miss). It never causes `rsp_hit`.
- R5: Each victim output names the lowest-numbered invalid way of its set. When all four ways are valid, it follows a 3-bit tree per set:
  - bit0=0 selects way bit1 (0 or 1);
  - bit0=1 selects way 2+bit2.
- R6: Each of these events updates the tree of its set, in this order: a directory hit, then a page hit, then a refill. Using way w sets bit0 = (w<2). For w<2 it then sets bit1 = (w==0); otherwise it sets bit2 = (w==2). Misses, flushes and invalidates leave the tree unchanged.
- R7: `flush_req` invalidates, in one cycle, every entry whose bit 8 (global) is 0. Entries with bit 8 set stay valid.
- R8: `inv_req` invalidates the page entry with a matching tag in set inv_vpn[3:0]. It also invalidates the directory entry with matching vpn[19:10] in set inv_vpn[13:10]. Both are removed even when they are global.
- R9: A refill writes set/way/tag/type/entry and sets valid. A lookup of the same page in the next cycle hits. A refill overrides a flush or invalidate of the same entry in the same cycle.
- R10: After reset all entries are invalid and every tree is zero. All response outputs are zero.
- R11: `rsp_valid` is high exactly in the cycle after a cycle with `lk_req` high. All other response outputs hold their value between lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_off | input | 12 | Page offset, passed to the physical address |
| fill_req | input | 1 | Refill write strobe |
| fill_vpn | input | 20 | Page number of the refilled entry |
| fill_dir | input | 1 | 1 = directory-level entry, 0 = page-level entry |
| fill_way | input | 2 | Way to write (the victim from the lookup) |
| fill_ent | input | 32 | Entry word; bit 8 is the global bit |
| flush_req | input | 1 | Task-switch flush of non-global entries |
| inv_req | input | 1 | Single-page invalidate strobe |
| inv_vpn | input | 20 | Page number to invalidate |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Page-level hit |
| rsp_paddr | output | 32 | Physical address on a hit |
| rsp_ent | output | 32 | Page-level entry on a hit |
| rsp_dir_hit | output | 1 | Directory-level entry present |
| rsp_dir_ent | output | 32 | Directory-level entry on a hit |
| rsp_victim | output | 2 | Refill way for the page-level set |
| rsp_dir_victim | output | 2 | Refill way for the directory-level set |

## Verification
The assertions take for granted that the walker never refills a page or directory entry that is already held. At most one way of a set can then match a lookup. They also assume the walker refills only into the victim way it was given. The stimulus keeps to this by refilling only after a lookup of that page has reported a miss of the matching kind. It uses the victim reported by that lookup. The directed part instead writes chosen ways into sets it knows to be empty, or whose victim it has computed.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int WAYS       = 4;
  localparam int WAY_W      = 2;
  localparam int PLRU_W     = 3;
  localparam int GLOBAL_BIT = 8;

  // tree walk when every way is valid
  function automatic logic [WAY_W-1:0] plru_pick(input logic [PLRU_W-1:0] t);
    return t[0] ? {1'b1, t[2]} : {1'b0, t[1]};
  endfunction

  // point the tree away from the way just used
  function automatic logic [PLRU_W-1:0] plru_touch(input logic [PLRU_W-1:0] t,
                                                   input logic [WAY_W-1:0] w);
    logic [PLRU_W-1:0] n;
    n    = t;
    n[0] = ~w[1];
    if (!w[1]) n[1] = ~w[0];
    else       n[2] = ~w[0];
    return n;
  endfunction
endpackage

// File: rtl/tlb_way_match.sv
module tlb_way_match
  import tlb_pkg::*;
#(
  parameter int TAG_W    = 16,
  parameter int CMP_W    = 16,
  parameter bit WANT_DIR = 1'b0
) (
  input  logic [WAYS-1:0]            valid,
  input  logic [WAYS-1:0]            dir,
  input  logic [WAYS-1:0][TAG_W-1:0] tag,
  input  logic [TAG_W-1:0]           key,
  output logic                       hit,
  output logic [WAY_W-1:0]           way
);
  localparam logic [TAG_W-1:0] MASK = {TAG_W{1'b1}} << (TAG_W - CMP_W);

  logic [WAYS-1:0] hv;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hv[w] = valid[w] && (dir[w] == WANT_DIR) && (((tag[w] ^ key) & MASK) == '0);
  end

  always_comb begin
    hit = |hv;
    way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hv[w]) way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel
  import tlb_pkg::*;
(
  input  logic [WAYS-1:0]   valid,
  input  logic [PLRU_W-1:0] tree,
  output logic [WAY_W-1:0]  way
);
  always_comb begin
    way = plru_pick(tree);
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid[w]) way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int SET_W  = 4,
  parameter int TAG_W  = 16,
  parameter int DTAG_W = 10,
  parameter int ENT_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [SET_W-1:0]           a_set,
  input  logic [SET_W-1:0]           b_set,
  output logic [WAYS-1:0]            a_valid,
  output logic [WAYS-1:0]            a_dir,
  output logic [WAYS-1:0][TAG_W-1:0] a_tag,
  output logic [WAYS-1:0][ENT_W-1:0] a_ent,
  output logic [PLRU_W-1:0]          a_plru,
  output logic [WAYS-1:0]            b_valid,
  output logic [WAYS-1:0]            b_dir,
  output logic [WAYS-1:0][TAG_W-1:0] b_tag,
  output logic [WAYS-1:0][ENT_W-1:0] b_ent,
  output logic [PLRU_W-1:0]          b_plru,
  input  logic                       touch_a,
  input  logic [WAY_W-1:0]           touch_a_way,
  input  logic                       touch_b,
  input  logic [WAY_W-1:0]           touch_b_way,
  input  logic                       wr_en,
  input  logic [SET_W-1:0]           wr_set,
  input  logic [WAY_W-1:0]           wr_way,
  input  logic                       wr_dir,
  input  logic [TAG_W-1:0]           wr_tag,
  input  logic [ENT_W-1:0]           wr_ent,
  input  logic                       flush,
  input  logic                       inv_en,
  input  logic [SET_W-1:0]           inv_tset,
  input  logic [SET_W-1:0]           inv_dset,
  input  logic [TAG_W-1:0]           inv_tag
);
  localparam int SETS = 1 << SET_W;
  localparam logic [TAG_W-1:0] DMASK = {TAG_W{1'b1}} << (TAG_W - DTAG_W);

  logic [WAYS-1:0]   valid_q [SETS];
  logic [WAYS-1:0]   dir_q   [SETS];
  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [ENT_W-1:0]  ent_q   [SETS][WAYS];
  logic [PLRU_W-1:0] plru_q  [SETS];
  logic [PLRU_W-1:0] plru_d  [SETS];

  always_comb begin
    a_valid = valid_q[a_set];
    a_dir   = dir_q[a_set];
    a_plru  = plru_q[a_set];
    b_valid = valid_q[b_set];
    b_dir   = dir_q[b_set];
    b_plru  = plru_q[b_set];
    for (int w = 0; w < WAYS; w++) begin
      a_tag[w] = tag_q[a_set][w];
      a_ent[w] = ent_q[a_set][w];
      b_tag[w] = tag_q[b_set][w];
      b_ent[w] = ent_q[b_set][w];
    end
  end

  // tree updates compose in a fixed order: directory hit, page hit, refill
  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      plru_d[s] = plru_q[s];
      if (touch_b && (b_set  == SET_W'(s))) plru_d[s] = plru_touch(plru_d[s], touch_b_way);
      if (touch_a && (a_set  == SET_W'(s))) plru_d[s] = plru_touch(plru_d[s], touch_a_way);
      if (wr_en   && (wr_set == SET_W'(s))) plru_d[s] = plru_touch(plru_d[s], wr_way);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        plru_q[s]  <= '0;
      end
    end else begin
      for (int s = 0; s < SETS; s++) begin
        plru_q[s] <= plru_d[s];
        for (int w = 0; w < WAYS; w++) begin
          if (flush && !ent_q[s][w][GLOBAL_BIT])
            valid_q[s][w] <= 1'b0;
          if (inv_en && (inv_tset == SET_W'(s)) && !dir_q[s][w] && (tag_q[s][w] == inv_tag))
            valid_q[s][w] <= 1'b0;
          if (inv_en && (inv_dset == SET_W'(s)) && dir_q[s][w] &&
              (((tag_q[s][w] ^ inv_tag) & DMASK) == '0))
            valid_q[s][w] <= 1'b0;
        end
      end
      if (wr_en) valid_q[wr_set][wr_way] <= 1'b1;
    end
  end

  // payload arrays carry no reset so they can map onto RAM
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set][wr_way]  <= wr_tag;
      ent_q[wr_set][wr_way]  <= wr_ent;
      dir_q[wr_set][wr_way]  <= wr_dir;
    end
  end
endmodule

// File: rtl/set_assoc_tlb.sv
module set_assoc_tlb
  import tlb_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int OFF_W = 12,
  parameter int SET_W = 4,
  parameter int DIR_W = 10,
  parameter int ENT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_req,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [OFF_W-1:0] lk_off,
  input  logic             fill_req,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic             fill_dir,
  input  logic [WAY_W-1:0] fill_way,
  input  logic [ENT_W-1:0] fill_ent,
  input  logic             flush_req,
  input  logic             inv_req,
  input  logic [VPN_W-1:0] inv_vpn,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [ENT_W-1:0] rsp_paddr,
  output logic [ENT_W-1:0] rsp_ent,
  output logic             rsp_dir_hit,
  output logic [ENT_W-1:0] rsp_dir_ent,
  output logic [WAY_W-1:0] rsp_victim,
  output logic [WAY_W-1:0] rsp_dir_victim
);
  localparam int TAG_W  = VPN_W - SET_W;
  localparam int DTAG_W = VPN_W - DIR_W;

  logic [SET_W-1:0]           t_set, d_set, f_set;
  logic [WAYS-1:0]            a_valid, a_dir, b_valid, b_dir;
  logic [WAYS-1:0][TAG_W-1:0] a_tag, b_tag;
  logic [WAYS-1:0][ENT_W-1:0] a_ent, b_ent;
  logic [PLRU_W-1:0]          a_plru, b_plru;
  logic                       t_hit, d_hit;
  logic [WAY_W-1:0]           t_way, d_way, t_vic, d_vic;
  logic [TAG_W-1:0]           lk_tag;

  assign t_set  = lk_vpn[SET_W-1:0];
  assign d_set  = lk_vpn[DIR_W +: SET_W];
  assign lk_tag = lk_vpn[VPN_W-1:SET_W];
  assign f_set  = fill_dir ? fill_vpn[DIR_W +: SET_W] : fill_vpn[SET_W-1:0];

  tlb_store #(
    .SET_W(SET_W), .TAG_W(TAG_W), .DTAG_W(DTAG_W), .ENT_W(ENT_W)
  ) u_store (
    .clk(clk), .rst(rst),
    .a_set(t_set), .b_set(d_set),
    .a_valid(a_valid), .a_dir(a_dir), .a_tag(a_tag), .a_ent(a_ent), .a_plru(a_plru),
    .b_valid(b_valid), .b_dir(b_dir), .b_tag(b_tag), .b_ent(b_ent), .b_plru(b_plru),
    .touch_a(lk_req && t_hit), .touch_a_way(t_way),
    .touch_b(lk_req && d_hit), .touch_b_way(d_way),
    .wr_en(fill_req), .wr_set(f_set), .wr_way(fill_way), .wr_dir(fill_dir),
    .wr_tag(fill_vpn[VPN_W-1:SET_W]), .wr_ent(fill_ent),
    .flush(flush_req), .inv_en(inv_req),
    .inv_tset(inv_vpn[SET_W-1:0]), .inv_dset(inv_vpn[DIR_W +: SET_W]),
    .inv_tag(inv_vpn[VPN_W-1:SET_W])
  );

  tlb_way_match #(.TAG_W(TAG_W), .CMP_W(TAG_W), .WANT_DIR(1'b0)) u_tmatch (
    .valid(a_valid), .dir(a_dir), .tag(a_tag), .key(lk_tag), .hit(t_hit), .way(t_way)
  );

  tlb_way_match #(.TAG_W(TAG_W), .CMP_W(DTAG_W), .WANT_DIR(1'b1)) u_dmatch (
    .valid(b_valid), .dir(b_dir), .tag(b_tag), .key(lk_tag), .hit(d_hit), .way(d_way)
  );

  tlb_victim_sel u_tvic (.valid(a_valid), .tree(a_plru), .way(t_vic));
  tlb_victim_sel u_dvic (.valid(b_valid), .tree(b_plru), .way(d_vic));

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid      <= 1'b0;
      rsp_hit        <= 1'b0;
      rsp_paddr      <= '0;
      rsp_ent        <= '0;
      rsp_dir_hit    <= 1'b0;
      rsp_dir_ent    <= '0;
      rsp_victim     <= '0;
      rsp_dir_victim <= '0;
    end else begin
      rsp_valid <= lk_req;
      if (lk_req) begin
        rsp_hit        <= t_hit;
        rsp_ent        <= t_hit ? a_ent[t_way] : '0;
        rsp_paddr      <= t_hit ? {a_ent[t_way][ENT_W-1:OFF_W], lk_off} : '0;
        rsp_dir_hit    <= d_hit;
        rsp_dir_ent    <= d_hit ? b_ent[d_way] : '0;
        rsp_victim     <= t_vic;
        rsp_dir_victim <= d_vic;
      end
    end
  end
endmodule

// File: rtl/set_assoc_tlb_chk.sv
module set_assoc_tlb_chk
  import tlb_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int OFF_W = 12,
  parameter int ENT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_req,
  input logic [VPN_W-1:0] lk_vpn,
  input logic [OFF_W-1:0] lk_off,
  input logic             fill_req,
  input logic [VPN_W-1:0] fill_vpn,
  input logic             fill_dir,
  input logic             flush_req,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [ENT_W-1:0] rsp_paddr,
  input logic [ENT_W-1:0] rsp_ent,
  input logic             rsp_dir_hit,
  input logic [ENT_W-1:0] rsp_dir_ent
);
  // R11
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> rsp_valid);

  // R11
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !rsp_valid);

  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> (!rsp_hit || rsp_paddr[OFF_W-1:0] == $past(lk_off)));

  // R3
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0 && rsp_ent == '0));

  // R9
  refill_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_req && !fill_dir) ##1 (lk_req && lk_vpn == $past(fill_vpn)) |=> rsp_hit);

  // R7
  flush_keeps_global_chk: assert property (@(posedge clk) disable iff (rst)
    (flush_req && !fill_req) ##1 lk_req |=> (!rsp_hit || rsp_ent[GLOBAL_BIT]));

  // R7
  flush_dir_global_chk: assert property (@(posedge clk) disable iff (rst)
    (flush_req && !fill_req) ##1 lk_req |=> (!rsp_dir_hit || rsp_dir_ent[GLOBAL_BIT]));
endmodule

bind set_assoc_tlb set_assoc_tlb_chk #(
  .VPN_W(VPN_W), .OFF_W(OFF_W), .ENT_W(ENT_W)
) u_chk (
  .clk(clk), .rst(rst), .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_off(lk_off),
  .fill_req(fill_req), .fill_vpn(fill_vpn), .fill_dir(fill_dir), .flush_req(flush_req),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr), .rsp_ent(rsp_ent),
  .rsp_dir_hit(rsp_dir_hit), .rsp_dir_ent(rsp_dir_ent)
);

// File: tb/set_assoc_tlb_tb.sv
module set_assoc_tlb_tb;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_req = 1'b0;
  logic [19:0] lk_vpn = '0;
  logic [11:0] lk_off = '0;
  logic        fill_req = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic        fill_dir = 1'b0;
  logic [1:0]  fill_way = '0;
  logic [31:0] fill_ent = '0;
  logic        flush_req = 1'b0;
  logic        inv_req = 1'b0;
  logic [19:0] inv_vpn = '0;
  logic        rsp_valid, rsp_hit, rsp_dir_hit;
  logic [31:0] rsp_paddr, rsp_ent, rsp_dir_ent;
  logic [1:0]  rsp_victim, rsp_dir_victim;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  set_assoc_tlb u_dut (
    .clk(clk), .rst(rst), .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_off(lk_off),
    .fill_req(fill_req), .fill_vpn(fill_vpn), .fill_dir(fill_dir), .fill_way(fill_way),
    .fill_ent(fill_ent), .flush_req(flush_req), .inv_req(inv_req), .inv_vpn(inv_vpn),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr), .rsp_ent(rsp_ent),
    .rsp_dir_hit(rsp_dir_hit), .rsp_dir_ent(rsp_dir_ent), .rsp_victim(rsp_victim),
    .rsp_dir_victim(rsp_dir_victim)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  bit          m_v   [16][4];
  bit          m_d   [16][4];
  bit [15:0]   m_tag [16][4];
  bit [31:0]   m_ent [16][4];
  bit [2:0]    m_t   [16];
  bit          e_valid;
  bit          e_hit, e_dhit;
  bit [31:0]   e_paddr, e_ent, e_dent;
  bit [1:0]    e_vic, e_dvic;

  function automatic int pick(input int s);
    for (int w = 0; w < 4; w++) if (!m_v[s][w]) return w;
    if (!m_t[s][0]) return m_t[s][1] ? 1 : 0;
    return m_t[s][2] ? 3 : 2;
  endfunction

  task automatic touch(input int s, input int w);
    if (w < 2) begin m_t[s][0] = 1'b1; m_t[s][1] = (w == 0); end
    else       begin m_t[s][0] = 1'b0; m_t[s][2] = (w == 2); end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < 16; s++) begin
        m_t[s] = '0;
        for (int w = 0; w < 4; w++) m_v[s][w] = 1'b0;
      end
      e_valid = 1'b0; e_hit = 1'b0; e_dhit = 1'b0; e_paddr = '0; e_ent = '0;
      e_dent = '0; e_vic = '0; e_dvic = '0;
    end else begin
      int ts, ds, fs, thw, dhw;
      e_valid = lk_req;
      if (lk_req) begin
        ts = int'(lk_vpn[3:0]); ds = int'(lk_vpn[13:10]);
        e_hit = 1'b0; e_dhit = 1'b0; thw = 0; dhw = 0;
        for (int w = 3; w >= 0; w--) begin
          if (m_v[ts][w] && !m_d[ts][w] && m_tag[ts][w] == lk_vpn[19:4]) begin e_hit = 1'b1; thw = w; end
          if (m_v[ds][w] && m_d[ds][w] && m_tag[ds][w][15:6] == lk_vpn[19:10]) begin e_dhit = 1'b1; dhw = w; end
        end
        e_ent   = e_hit  ? m_ent[ts][thw] : '0;
        e_paddr = e_hit  ? {e_ent[31:12], lk_off} : '0;
        e_dent  = e_dhit ? m_ent[ds][dhw] : '0;
        e_vic   = 2'(pick(ts));
        e_dvic  = 2'(pick(ds));
        if (e_dhit) touch(ds, dhw);
        if (e_hit)  touch(ts, thw);
      end
      fs = fill_dir ? int'(fill_vpn[13:10]) : int'(fill_vpn[3:0]);
      if (fill_req) touch(fs, int'(fill_way));
      for (int s = 0; s < 16; s++)
        for (int w = 0; w < 4; w++) begin
          if (flush_req && !m_ent[s][w][8]) m_v[s][w] = 1'b0;
          if (inv_req && s == int'(inv_vpn[3:0]) && !m_d[s][w] && m_tag[s][w] == inv_vpn[19:4])
            m_v[s][w] = 1'b0;
          if (inv_req && s == int'(inv_vpn[13:10]) && m_d[s][w] && m_tag[s][w][15:6] == inv_vpn[19:10])
            m_v[s][w] = 1'b0;
        end
      if (fill_req) begin
        m_v[fs][fill_way] = 1'b1; m_d[fs][fill_way] = fill_dir;
        m_tag[fs][fill_way] = fill_vpn[19:4]; m_ent[fs][fill_way] = fill_ent;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R11", "rsp_valid", 32'(rsp_valid), 32'(e_valid));
      if (e_valid) begin
        chk("R2",  "rsp_hit",        32'(rsp_hit),        32'(e_hit));
        chk("R2",  "rsp_paddr",      rsp_paddr,           e_paddr);
        chk("R3",  "rsp_ent",        rsp_ent,             e_ent);
        chk("R4",  "rsp_dir_hit",    32'(rsp_dir_hit),    32'(e_dhit));
        chk("R4",  "rsp_dir_ent",    rsp_dir_ent,         e_dent);
        chk("R5",  "rsp_victim",     32'(rsp_victim),     32'(e_vic));
        chk("R6",  "rsp_dir_victim", 32'(rsp_dir_victim), 32'(e_dvic));
      end
    end
  end

  // ---------------- stimulus tasks (entered at a falling edge) ----------------
  task automatic look(input logic [19:0] v, input logic [11:0] o);
    lk_req = 1'b1; lk_vpn = v; lk_off = o;
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  task automatic fill(input logic [19:0] v, input bit d, input logic [1:0] w,
                      input logic [31:0] e);
    fill_req = 1'b1; fill_vpn = v; fill_dir = d; fill_way = w; fill_ent = e;
    @(negedge clk);
    fill_req = 1'b0;
  endtask

  task automatic flush();
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
  endtask

  task automatic inval(input logic [19:0] v);
    inv_req = 1'b1; inv_vpn = v;
    @(negedge clk);
    inv_req = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs cleared by reset
    chk("R10", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
    chk("R10", "rsp_paddr in reset", rsp_paddr, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // R10: empty after reset
    look(20'h12345, 12'h000);
    chk("R10", "miss after reset", 32'(rsp_hit), 32'd0);
    chk("R10", "victim after reset", 32'(rsp_victim), 32'd0);

    // R9 / R2: refill then immediate hit
    fill(20'h12345, 1'b0, 2'd0, 32'hABCDE001);
    look(20'h12345, 12'h678);
    chk("R9", "hit after refill", 32'(rsp_hit), 32'd1);
    chk("R2", "paddr", rsp_paddr, 32'hABCDE678);

    // R5: invalid ways first, then tree
    look(20'h00015, 12'h0);
    chk("R5", "first invalid way", 32'(rsp_victim), 32'd1);
    fill(20'h00015, 1'b0, 2'd1, 32'h11111001);
    look(20'h00025, 12'h0);
    chk("R5", "second invalid way", 32'(rsp_victim), 32'd2);
    fill(20'h00025, 1'b0, 2'd2, 32'h22222001);
    look(20'h00035, 12'h0);
    fill(20'h00035, 1'b0, 2'd3, 32'h33333001);
    look(20'h00045, 12'h0);
    chk("R6", "tree victim full set", 32'(rsp_victim), 32'd0);
    look(20'h12345, 12'h0);
    look(20'h00045, 12'h0);
    chk("R6", "tree victim after hit", 32'(rsp_victim), 32'd2);

    // R1: other set independent
    fill(20'h00016, 1'b0, 2'd0, 32'h44444001);
    look(20'h00015, 12'h0);
    chk("R1", "set 5 unaffected", 32'(rsp_hit), 32'd1);
    look(20'h00016, 12'hABC);
    chk("R1", "set 6 paddr", rsp_paddr, 32'h44444ABC);

    // R4: directory entry matched on upper bits only
    fill(20'h12C00, 1'b1, 2'd0, 32'h00777027);
    look(20'h12C3F, 12'h0);
    chk("R4", "dir hit", 32'(rsp_dir_hit), 32'd1);
    chk("R4", "dir entry", rsp_dir_ent, 32'h00777027);
    chk("R4", "dir gives no page hit", 32'(rsp_hit), 32'd0);
    look(20'h12800, 12'h0);
    chk("R4", "dir miss other region", 32'(rsp_dir_hit), 32'd0);

    // R7: flush keeps global
    fill(20'h22222, 1'b0, 2'd0, 32'h11111100);
    flush();
    look(20'h22222, 12'h0);
    chk("R7", "global survives", 32'(rsp_hit), 32'd1);
    look(20'h12345, 12'h0);
    chk("R7", "non-global dropped", 32'(rsp_hit), 32'd0);
    look(20'h12C3F, 12'h0);
    chk("R7", "dir dropped", 32'(rsp_dir_hit), 32'd0);

    // R8: single invalidate
    fill(20'h33333, 1'b0, 2'd0, 32'h55555001);
    inval(20'h33333);
    look(20'h33333, 12'h0);
    chk("R8", "page invalidated", 32'(rsp_hit), 32'd0);
    inval(20'h22222);
    look(20'h22222, 12'h0);
    chk("R8", "global invalidated", 32'(rsp_hit), 32'd0);
    fill(20'h12C00, 1'b1, 2'd0, 32'h00777027);
    inval(20'h12C3F);
    look(20'h12C00, 12'h0);
    chk("R8", "dir invalidated", 32'(rsp_dir_hit), 32'd0);

    // R9: refill beats flush in same cycle
    flush_req = 1'b1;
    fill(20'h44444, 1'b0, 2'd0, 32'h66666001);
    flush_req = 1'b0;
    look(20'h44444, 12'h0);
    chk("R9", "refill over flush", 32'(rsp_hit), 32'd1);

    // mixed traffic, walker-style refills
    for (int i = 0; i < 3000; i++) begin
      logic [19:0] v;
      v = {6'd0, 4'($urandom % 3), 6'($urandom % 6), 4'($urandom % 4)};
      look(v, 12'($urandom));
      if (!rsp_hit && ($urandom % 2 == 0))
        fill(v, 1'b0, rsp_victim, {20'($urandom), 3'd0, 1'($urandom % 4 == 0), 8'h01});
      else if (!rsp_dir_hit && ($urandom % 3 == 0))
        fill(v, 1'b1, rsp_dir_victim, {20'($urandom), 3'd0, 1'($urandom % 4 == 0), 8'h01});
      if ($urandom % 60 == 0) flush();
      if ($urandom % 25 == 0) inval({6'd0, 4'($urandom % 3), 6'($urandom % 6), 4'($urandom % 4)});
    end

    @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule